// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt lines from on-chip peripherals and from a small set of external pins, latches each one in a per-source pending bit, and tells the processor which pending source to serve next. Each source has a pending bit, an enable bit, a five-bit priority made of a three-bit major level and a two-bit sub level, and a 32-bit vector offset word. All of these are reached over a simple 32-bit register bus.

Peripheral sources come in two kinds, chosen per source by a parameter. An edge source latches on a rising input transition and then stays pending until software clears it. A persistent source is forced pending for as long as its input is high, so software has to remove the cause before its clear takes effect. External pins always behave as edge sources, and each pin has a polarity bit in the control register. The pending, enable and priority banks each have a plain-write address, a write-one-to-clear alias and a write-one-to-set alias, so software can change single bits without a read-modify-write.

The arbiter continuously selects the best eligible source. It drives the processor request line and shows the selected source number in the status register.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The pending, enable and priority banks each have three addresses per register: register base +0x0 for a plain write, +0x4 where a 1 clears the bit, and +0x8 where a 1 sets the bit. A 0 written to either alias leaves that bit unchanged, and a read at any of the three addresses returns the register contents.
- R2: The pending bank starts at 0x040 and the enable bank at 0x0C0. Source n maps to register n/32 of the bank, at bit n%32, and registers in a bank are 0x10 apart. Bits for source numbers at or above the source count read 0.
- R3: The priority bank starts at 0x140 and holds four sources per register, 0x10 apart. Source n uses byte lane n%4, bits [8*(n%4)+4 : 8*(n%4)]. In each field, bits [4:2] are the major level and bits [1:0] the sub level. Bits 5 to 7 of each lane read 0.
- R4: For an edge peripheral source, the pending bit is set on the clock edge that first samples the input high after it was low. The bit then stays set whatever the input does, until software clears it. An input that is held high does not set the bit again.
- R5: For a persistent source, the pending bit is set on every clock edge that samples the input high. A clear written while the input is high has no effect. After the input has gone low, a clear takes effect.
- R6: External pin k is source number NUM_SRC+k. Control register (0x000) bit k selects the pin's edge: 1 for rising, 0 for falling.
- R7: A source is eligible when it is pending, enabled and has a nonzero major level. Among eligible sources, the one with the largest 5-bit priority value wins. Ties go to the lowest source number.
- R8: The status register at 0x020 returns the winning source number in bits [7:0] and zero in bits [31:8]. It reads 0 when no source is eligible.
- R9: cpuIrq is high exactly when at least one source is eligible. A source whose major level is 0 never raises it.
- R10: The vector offset word of source n is a 32-bit plain read/write register at 0x540 + 4*n.
- R11: Reset clears all pending, enable, priority, control and vector state, and leaves cpuIrq low and status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 12 | Byte address of the register access |
| busWe | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| srcIn | input | NUM_SRC | Peripheral interrupt lines |
| extIn | input | NUM_EXT | External interrupt pins |
| cpuIrq | output | 1 | Interrupt request to the processor |

## Verification
Four properties are checked on every cycle. A nonzero request always points at a source that is pending, enabled and has a nonzero major level. A persistent source whose input was high is pending on the following cycle. No pending bit drops without a bus write. The status register reads zero while the request is low. Other behaviour can only be shown through the bench's scenarios: the alias write semantics, lane and bit packing, edge versus level capture, external polarity selection, tie-breaking toward the lowest number, and the vector words. A random phase then compares the status register and the request against a model after each random bank write.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  localparam int unsigned ADDR_CTRL = 32'h000;
  localparam int unsigned ADDR_STAT = 32'h020;
  localparam int unsigned ADDR_FLAG = 32'h040;
  localparam int unsigned ADDR_ENAB = 32'h0C0;
  localparam int unsigned ADDR_PRIO = 32'h140;
  localparam int unsigned ADDR_VECT = 32'h540;

  typedef enum logic [2:0] {
    BK_NONE, BK_CTRL, BK_STAT, BK_FLAG, BK_ENAB, BK_PRIO, BK_VECT
  } bank_e;

  // value equals the address bits [3:2] inside a bank register slot
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0, OP_CLEAR = 2'd1, OP_SET = 2'd2, OP_NONE = 2'd3
  } wrOp_e;

  typedef struct packed {
    bank_e      bank;
    wrOp_e      op;
    logic [7:0] idx;
    logic       wr;
  } busStrobe_t;

  function automatic logic bitOp(wrOp_e op, logic cur, logic d);
    case (op)
      OP_WRITE: return d;
      OP_CLEAR: return cur & ~d;
      OP_SET:   return cur | d;
      default:  return cur;
    endcase
  endfunction

endpackage

// File: rtl/irqv_decode.sv
module irqv_decode
  import irqv_pkg::*;
#(
  parameter int TOT = 72
) (
  input  logic [11:0] busAddr,
  input  logic        busWe,
  output busStrobe_t  strb
);
  localparam int unsigned FE_REGS  = (TOT + 31) / 32;
  localparam int unsigned PRI_REGS = (TOT + 3) / 4;

  always_comb begin
    int unsigned a;
    a = 32'(busAddr);
    strb.bank = BK_NONE;
    strb.op   = OP_NONE;
    strb.idx  = '0;
    if (busAddr[1:0] == 2'b00) begin
      if (a == ADDR_CTRL) begin
        strb.bank = BK_CTRL;
        strb.op   = OP_WRITE;
      end else if (a == ADDR_STAT) begin
        strb.bank = BK_STAT;
      end else if (a >= ADDR_FLAG && a < ADDR_FLAG + 16 * FE_REGS) begin
        strb.bank = BK_FLAG;
        strb.op   = wrOp_e'(2'((a - ADDR_FLAG) >> 2));
        strb.idx  = 8'((a - ADDR_FLAG) >> 4);
      end else if (a >= ADDR_ENAB && a < ADDR_ENAB + 16 * FE_REGS) begin
        strb.bank = BK_ENAB;
        strb.op   = wrOp_e'(2'((a - ADDR_ENAB) >> 2));
        strb.idx  = 8'((a - ADDR_ENAB) >> 4);
      end else if (a >= ADDR_PRIO && a < ADDR_PRIO + 16 * PRI_REGS) begin
        strb.bank = BK_PRIO;
        strb.op   = wrOp_e'(2'((a - ADDR_PRIO) >> 2));
        strb.idx  = 8'((a - ADDR_PRIO) >> 4);
      end else if (a >= ADDR_VECT && a < ADDR_VECT + 4 * TOT) begin
        strb.bank = BK_VECT;
        strb.op   = OP_WRITE;
        strb.idx  = 8'((a - ADDR_VECT) >> 2);
      end
    end
    strb.wr = busWe && (strb.op != OP_NONE);
  end

endmodule

// File: rtl/irqv_regs.sv
module irqv_regs
  import irqv_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_EXT = 8,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0,
  localparam int TOT = NUM_SRC + NUM_EXT,
  localparam int IDW = $clog2(TOT)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  busStrobe_t             strb,
  input  logic [31:0]            busWdata,
  input  logic [NUM_SRC-1:0]     srcIn,
  input  logic [NUM_EXT-1:0]     extIn,
  input  logic                   winValid,
  input  logic [7:0]             winId,
  output logic [TOT-1:0]         flagQ,
  output logic [TOT-1:0]         enQ,
  output logic [TOT-1:0][4:0]    priQ,
  output logic [31:0]            rdWord
);
  logic [NUM_EXT-1:0]     ctrlQ;
  logic [TOT-1:0][31:0]   vecQ;
  logic [TOT-1:0]         lineNow, lineQ, hwSet, flagD, enD;
  logic [TOT-1:0][4:0]    priD;

  // per-source capture: peripheral edge, peripheral level, external pin
  for (genvar n = 0; n < TOT; n++) begin : g_src
    if (n >= NUM_SRC) begin : g_ext
      assign lineNow[n] = extIn[n-NUM_SRC];
      assign hwSet[n]   = ctrlQ[n-NUM_SRC] ? (lineNow[n] & ~lineQ[n])
                                           : (~lineNow[n] & lineQ[n]);
    end else if (LEVEL_MASK[n]) begin : g_lvl
      assign lineNow[n] = srcIn[n];
      assign hwSet[n]   = srcIn[n];
    end else begin : g_edge
      assign lineNow[n] = srcIn[n];
      assign hwSet[n]   = srcIn[n] & ~lineQ[n];
    end
  end

  always_comb begin
    flagD = flagQ;
    enD   = enQ;
    priD  = priQ;
    for (int n = 0; n < TOT; n++) begin
      if (strb.wr && strb.bank == BK_FLAG && strb.idx == 8'(n / 32))
        flagD[n] = bitOp(strb.op, flagQ[n], busWdata[n % 32]);
      if (strb.wr && strb.bank == BK_ENAB && strb.idx == 8'(n / 32))
        enD[n] = bitOp(strb.op, enQ[n], busWdata[n % 32]);
      if (strb.wr && strb.bank == BK_PRIO && strb.idx == 8'(n / 4))
        for (int j = 0; j < 5; j++)
          priD[n][j] = bitOp(strb.op, priQ[n][j], busWdata[8*(n%4)+j]);
    end
    flagD = flagD | hwSet;   // hardware capture wins over a same-cycle clear
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= '0;
      enQ   <= '0;
      priQ  <= '0;
      ctrlQ <= '0;
      vecQ  <= '0;
      lineQ <= '0;
    end else begin
      flagQ <= flagD;
      enQ   <= enD;
      priQ  <= priD;
      lineQ <= lineNow;
      if (strb.wr && strb.bank == BK_CTRL) ctrlQ <= busWdata[NUM_EXT-1:0];
      if (strb.wr && strb.bank == BK_VECT) vecQ[strb.idx[IDW-1:0]] <= busWdata;
    end
  end

  always_comb begin
    rdWord = '0;
    case (strb.bank)
      BK_CTRL: rdWord[NUM_EXT-1:0] = ctrlQ;
      BK_STAT: if (winValid) rdWord[7:0] = winId;
      BK_FLAG, BK_ENAB:
        for (int b = 0; b < 32; b++) begin
          if (32 * int'(strb.idx) + b < TOT)
            rdWord[b] = (strb.bank == BK_FLAG) ? flagQ[32*int'(strb.idx)+b]
                                               : enQ[32*int'(strb.idx)+b];
        end
      BK_PRIO:
        for (int l = 0; l < 4; l++) begin
          if (4 * int'(strb.idx) + l < TOT)
            rdWord[8*l +: 5] = priQ[4*int'(strb.idx)+l];
        end
      BK_VECT: rdWord = vecQ[strb.idx[IDW-1:0]];
      default: rdWord = '0;
    endcase
  end

endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter #(
  parameter int TOT = 72
) (
  input  logic [TOT-1:0]      flagQ,
  input  logic [TOT-1:0]      enQ,
  input  logic [TOT-1:0][4:0] priQ,
  output logic                winValid,
  output logic [7:0]          winId
);
  logic [4:0] best;

  // ascending scan with strict compare keeps the lowest number on ties
  always_comb begin
    winValid = 1'b0;
    winId    = '0;
    best     = '0;
    for (int n = 0; n < TOT; n++) begin
      if (flagQ[n] && enQ[n] && priQ[n][4:2] != 3'd0 &&
          (!winValid || priQ[n] > best)) begin
        winValid = 1'b1;
        winId    = 8'(n);
        best     = priQ[n];
      end
    end
  end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_EXT = 8,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = 64'h0000_0000_FFFF_0000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [11:0]        busAddr,
  input  logic               busWe,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [NUM_EXT-1:0] extIn,
  output logic               cpuIrq
);
  localparam int TOT = NUM_SRC + NUM_EXT;

  busStrobe_t          strb;
  logic [TOT-1:0]      flagQ, enQ;
  logic [TOT-1:0][4:0] priQ;
  logic                winValid;
  logic [7:0]          winId;

  irqv_decode #(.TOT(TOT)) uDecode (
    .busAddr(busAddr), .busWe(busWe), .strb(strb)
  );

  irqv_regs #(.NUM_SRC(NUM_SRC), .NUM_EXT(NUM_EXT), .LEVEL_MASK(LEVEL_MASK)) uRegs (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .srcIn(srcIn), .extIn(extIn), .winValid(winValid), .winId(winId),
    .flagQ(flagQ), .enQ(enQ), .priQ(priQ), .rdWord(busRdata)
  );

  irqv_arbiter #(.TOT(TOT)) uArb (
    .flagQ(flagQ), .enQ(enQ), .priQ(priQ), .winValid(winValid), .winId(winId)
  );

  assign cpuIrq = winValid;

endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
  parameter int NUM_SRC = 64,
  parameter int NUM_EXT = 8,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0,
  localparam int TOT = NUM_SRC + NUM_EXT,
  localparam int IDW = $clog2(TOT)
) (
  input logic                clk,
  input logic                rstN,
  input logic                busWe,
  input logic [11:0]         busAddr,
  input logic [31:0]         busRdata,
  input logic [NUM_SRC-1:0]  srcIn,
  input logic [TOT-1:0]      flagQ,
  input logic [TOT-1:0]      enQ,
  input logic [TOT-1:0][4:0] priQ,
  input logic [7:0]          winId,
  input logic                cpuIrq
);
  // R7 / R9: a raised request names an eligible source
  p_winner_eligible_r7: assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq |-> (flagQ[winId[IDW-1:0]] && enQ[winId[IDW-1:0]] &&
                priQ[winId[IDW-1:0]][4:2] != 3'd0));

  // R5: a persistent input seen high leaves its source pending
  p_level_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (($past(srcIn) & LEVEL_MASK & ~flagQ[NUM_SRC-1:0]) == '0));

  // R4: pending bits only fall after a bus write
  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(busWe)) |-> (($past(flagQ) & ~flagQ) == '0));

  // R8: status reads zero while nothing is requested
  p_stat_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuIrq && busAddr == 12'h020) |-> busRdata == 32'd0);
endmodule

bind irq_vector_ctrl irqv_checker #(
  .NUM_SRC(NUM_SRC), .NUM_EXT(NUM_EXT), .LEVEL_MASK(LEVEL_MASK)
) uChk (
  .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busRdata(busRdata),
  .srcIn(srcIn), .flagQ(flagQ), .enQ(enQ), .priQ(priQ), .winId(winId),
  .cpuIrq(cpuIrq)
);

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
  localparam int NS = 64, NE = 8, TOT = NS + NE;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rstN;
  logic [11:0]   busAddr;
  logic          busWe;
  logic [31:0]   busWdata, busRdata;
  logic [NS-1:0] srcIn;
  logic [NE-1:0] extIn;
  logic          cpuIrq;

  int checks = 0, fails = 0;
  logic       mFlag [TOT];
  logic       mEn   [TOT];
  logic [4:0] mPri  [TOT];

  irq_vector_ctrl u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .srcIn(srcIn),
    .extIn(extIn), .cpuIrq(cpuIrq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clearAll();
    for (int r = 0; r < 3; r++) begin
      wr(12'(12'h044 + 16*r), 32'hFFFF_FFFF);
      wr(12'(12'h0C0 + 16*r), 32'h0);
    end
    for (int r = 0; r < 18; r++) wr(12'(12'h140 + 16*r), 32'h0);
  endtask

  function automatic logic modelOp(int op, logic cur, logic d);
    if (op == 0) return d;
    if (op == 1) return cur & ~d;
    return cur | d;
  endfunction

  function automatic logic [8:0] expWin();
    logic found = 1'b0;
    logic [7:0] id = '0;
    logic [4:0] best = '0;
    for (int n = 0; n < TOT; n++)
      if (mFlag[n] && mEn[n] && mPri[n][4:2] != 0 && (!found || mPri[n] > best)) begin
        found = 1'b1; id = 8'(n); best = mPri[n];
      end
    return {found, id};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [8:0] e;
    int kind, op, r;
    logic [11:0] a;
    logic [31:0] d;
    void'($urandom(32'h5EED_1234));
    rstN = 1'b0; busAddr = '0; busWe = 1'b0; busWdata = '0; srcIn = '0; extIn = '0;
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R11 reset state
    rd(12'h040, v); chk("R11 flag", v, 0);
    rd(12'h0C0, v); chk("R11 enable", v, 0);
    rd(12'h140, v); chk("R11 prio", v, 0);
    rd(12'h000, v); chk("R11 ctrl", v, 0);
    rd(12'h540, v); chk("R11 vector", v, 0);
    rd(12'h020, v); chk("R11 status", v, 0);
    chk("R11 irq", 32'(cpuIrq), 0);

    // R1 alias semantics on the enable bank
    wr(12'h0C0, 32'hF0); wr(12'h0C8, 32'h0F);
    rd(12'h0C0, v); chk("R1 set alias", v, 32'hFF);
    wr(12'h0C4, 32'h3C);
    rd(12'h0C4, v); chk("R1 clear alias read", v, 32'hC3);
    wr(12'h0C8, 32'h0);
    rd(12'h0C8, v); chk("R1 zero set no effect", v, 32'hC3);

    // R2 packing and unused high bits
    wr(12'h0D8, 32'h20);
    rd(12'h0D0, v); chk("R2 enable src37", v, 32'h20);
    wr(12'h048, 32'h200);
    rd(12'h040, v); chk("R2 flag src9", v, 32'h200);
    chk("R9 major zero no irq", 32'(cpuIrq), 0);
    wr(12'h068, 32'hFFFF_FFFF);
    rd(12'h060, v); chk("R2 flag reg2 width", v, 32'hFF);
    clearAll();

    // R3 priority lanes
    wr(12'h150, 32'hFFFF_FFFF);
    rd(12'h150, v); chk("R3 lane mask", v, 32'h1F1F_1F1F);
    wr(12'h154, 32'h00FF_0000);
    rd(12'h150, v); chk("R3 lane clear", v, 32'h1F00_1F1F);
    wr(12'h150, 32'h0A13_071C);
    rd(12'h158, v); chk("R3 plain write", v, 32'h0A13_071C);
    clearAll();

    // R4 edge source 3
    wr(12'h0C0, 32'h8); wr(12'h140, 32'h0800_0000);
    @(negedge clk) srcIn[3] = 1'b1;
    tick();
    rd(12'h040, v); chk("R4 edge capture", v, 32'h8);
    chk("R9 irq on edge", 32'(cpuIrq), 1);
    rd(12'h020, v); chk("R8 status src3", v, 3);
    srcIn[3] = 1'b0; tick(); tick();
    rd(12'h040, v); chk("R4 sticky after low", v, 32'h8);
    srcIn[3] = 1'b1; tick();
    wr(12'h044, 32'h8); tick();
    rd(12'h040, v); chk("R4 held high no reset", v, 0);
    chk("R9 irq drops", 32'(cpuIrq), 0);
    srcIn[3] = 1'b0;

    // R5 persistent source 20
    srcIn[20] = 1'b1; tick();
    rd(12'h040, v); chk("R5 level capture", v, 32'h0010_0000);
    wr(12'h044, 32'h0010_0000);
    rd(12'h040, v); chk("R5 clear ignored", v, 32'h0010_0000);
    srcIn[20] = 1'b0;
    wr(12'h044, 32'h0010_0000);
    rd(12'h040, v); chk("R5 clear after low", v, 0);

    // R6 external pin 2 = source 66
    extIn[2] = 1'b1; tick();
    rd(12'h060, v); chk("R6 falling ignores rise", v, 0);
    extIn[2] = 1'b0; tick();
    rd(12'h060, v); chk("R6 falling capture", v, 32'h4);
    wr(12'h064, 32'h4);
    wr(12'h000, 32'h4);
    rd(12'h000, v); chk("R6 ctrl read", v, 32'h4);
    extIn[2] = 1'b1; tick();
    rd(12'h060, v); chk("R6 rising capture", v, 32'h4);
    wr(12'h064, 32'h4);
    extIn[2] = 1'b0; tick();
    rd(12'h060, v); chk("R6 rising ignores fall", v, 0);
    clearAll();

    // R7 arbitration directed
    wr(12'h0C0, 32'hFFFF_FFFF);
    wr(12'h150, 32'h0000_000D);            // src4 {3,1}
    wr(12'h160, 32'h000E_0E00);            // src9, src10 {3,2}
    wr(12'h140, 32'h0000_0300);            // src1 {0,3}
    wr(12'h048, 32'h2);
    chk("R9 major zero only", 32'(cpuIrq), 0);
    wr(12'h048, 32'h610);
    rd(12'h020, v); chk("R7 tie lowest", v, 9);
    wr(12'h044, 32'h200);
    rd(12'h020, v); chk("R7 next best", v, 10);
    wr(12'h044, 32'h400);
    rd(12'h020, v); chk("R7 sub level order", v, 4);
    clearAll();

    // R10 vector words
    wr(12'(12'h540 + 4*5), 32'hDEAD_BEEF);
    wr(12'(12'h540 + 4*71), 32'h1234_5678);
    rd(12'(12'h540 + 4*5), v); chk("R10 vector 5", v, 32'hDEAD_BEEF);
    rd(12'(12'h540 + 4*6), v); chk("R10 vector 6 untouched", v, 0);
    rd(12'(12'h540 + 4*71), v); chk("R10 vector last", v, 32'h1234_5678);

    // random phase against the model (R1 R7 R8 R9)
    for (int n = 0; n < TOT; n++) begin mFlag[n] = 0; mEn[n] = 0; mPri[n] = 0; end
    for (int it = 0; it < 300; it++) begin
      kind = int'($urandom % 3);
      op   = int'($urandom % 3);
      d    = $urandom;
      if (kind < 2) begin
        r = int'($urandom % 3);
        a = 12'((kind == 0 ? 12'h040 : 12'h0C0) + 16*r + 4*op);
        for (int b = 0; b < 32; b++)
          if (32*r + b < TOT) begin
            if (kind == 0) mFlag[32*r+b] = modelOp(op, mFlag[32*r+b], d[b]);
            else           mEn[32*r+b]   = modelOp(op, mEn[32*r+b], d[b]);
          end
      end else begin
        r = int'($urandom % 18);
        a = 12'(12'h140 + 16*r + 4*op);
        for (int l = 0; l < 4; l++)
          for (int j = 0; j < 5; j++)
            mPri[4*r+l][j] = modelOp(op, mPri[4*r+l][j], d[8*l+j]);
      end
      wr(a, d);
      e = expWin();
      rd(12'h020, v); chk("R7 R8 random status", v, e[8] ? {24'd0, e[7:0]} : 32'd0);
      chk("R9 random irq", 32'(cpuIrq), 32'(e[8]));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule